// File: doc/BRIEF.md
# Large-Transfer Descriptor Chain Splitter

The splitter turns one copy request of arbitrary byte size into a chain of fixed-format descriptors that together form a single packet. Each descriptor carries at most 64 KiB. A 32-bit length/control word and a 64-bit buffer address describe each one. The chain is marked so a downstream engine can tell where the packet starts, where it continues and where it ends. Every chunk but the last is a full 64 KiB. A full chunk is written with a zero length field, because the 16-bit field cannot hold 65536.

Before any descriptor leaves the block, it works out how many chunks the request needs. It compares that count with a per-packet ceiling. The ceiling depends on the hardware generation and on whether the chain is for the transmit (read) or the receive (write) side. A request that needs too many descriptors, or one with a size of zero, is refused with a one-cycle error pulse, and no descriptor is produced for it.

Requests arrive on a valid/ready port and are taken one at a time. Descriptors leave on a valid/ready stream. A descriptor is taken on a cycle where both `dsc_valid` and `dsc_ready` are high. While `dsc_ready` is low, the offered descriptor stays fixed. `req_ready` stays low from the moment a request is taken until its final descriptor has been taken.

Top module: `desc_chain_splitter`

## Requirements
- R1: After reset, `dsc_valid` and `req_err` are 0 and `req_ready` is 1.
- R2: A request of size S yields ceil(S/65536) descriptors. Each one except the last has length field bits 15:0 equal to 0, meaning 65536 bytes. The last one carries S mod 65536, or 0 when S is an exact multiple of 65536.
- R3: The descriptor control word is laid out as follows. Bit 26 (start marker) is set only on the first descriptor. Bit 27 (end marker) is set only on the final one. Bit 31 (continue marker) is set on every descriptor except the final one. Bits 25:24 carry `req_phase`. All other bits outside 15:0 are 0. A single-descriptor chain has bits 26 and 27 set and bit 31 clear.
- R4: The first descriptor address equals `req_addr`. Each later address is the previous one plus 65536.
- R5: For transmit requests (`req_dir`=0), the descriptor ceiling is 128 when `req_gen` <= 2 and 65 otherwise. A request that needs exactly the ceiling is emitted in full.
- R6: For receive requests (`req_dir`=1), the descriptor ceiling is 128 when `req_gen` <= 2 and 60 otherwise. A request that needs exactly the ceiling is emitted in full.
- R7: A request that needs more descriptors than its ceiling raises `req_err` for exactly the one cycle after it is taken. No descriptor is emitted for it.
- R8: A request of size 0 is rejected in the same way as R7, with an error pulse and no descriptor.
- R9: While `dsc_valid` is 1 and `dsc_ready` is 0, the block holds `dsc_valid`, `dsc_ctrl` and `dsc_addr` unchanged on the next cycle.
- R10: `req_ready` is 0 while a chain is being emitted. It returns to 1 on the cycle after the final descriptor is taken. The first descriptor is offered on the cycle after its request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_size | input | 32 | Transfer size in bytes |
| req_addr | input | 64 | Start address |
| req_phase | input | 2 | Ring phase copied into bits 25:24 |
| req_gen | input | 3 | Hardware generation |
| req_dir | input | 1 | 0 = transmit, 1 = receive |
| req_err | output | 1 | One-cycle rejection pulse |
| dsc_valid | output | 1 | Descriptor offered |
| dsc_ready | input | 1 | Consumer takes the descriptor |
| dsc_ctrl | output | 32 | Length/control word |
| dsc_addr | output | 64 | Descriptor buffer address |

## Verification
The assertions assume the request fields are meaningful only on the cycle where `req_valid` and `req_ready` are both high. They also assume the consumer may drop `dsc_ready` at any time. The assertions assume that address arithmetic never wraps the 64-bit range. The bench drives every input half a cycle away from the active edge. It places start addresses well below the top of the address space. It raises `req_valid` only for a single cycle, and only while `req_ready` is high. Back-pressure is applied by lowering `dsc_ready` on chosen descriptors, including the first and the final one of a chain.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  localparam int CHUNK_LOG  = 16;
  localparam int CTRL_W     = 32;
  localparam int BIT_CONT   = 31;
  localparam int BIT_END    = 27;
  localparam int BIT_START  = 26;
  localparam int PHASE_LO   = 24;
  localparam int PHASE_W    = 2;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/desc_limit_sel.sv
module desc_limit_sel
  import splitter_pkg::*;
#(
  parameter int GEN_W      = 3,
  parameter int CNT_W      = 17,
  parameter int LEGACY_GEN = 2,
  parameter int TX_LEGACY  = 128,
  parameter int RX_LEGACY  = 128,
  parameter int TX_NEWER   = 65,
  parameter int RX_NEWER   = 60
) (
  input  logic [GEN_W-1:0] gen,
  input  xfer_dir_e        dir,
  output logic [CNT_W-1:0] limit
);
  logic legacy;
  assign legacy = (int'(gen) <= LEGACY_GEN);

  always_comb begin
    unique case ({legacy, dir})
      {1'b1, DIR_TX}: limit = CNT_W'(TX_LEGACY);
      {1'b1, DIR_RX}: limit = CNT_W'(RX_LEGACY);
      {1'b0, DIR_TX}: limit = CNT_W'(TX_NEWER);
      default:        limit = CNT_W'(RX_NEWER);
    endcase
  end
endmodule

// File: rtl/desc_count_calc.sv
module desc_count_calc
  import splitter_pkg::*;
#(
  parameter int SIZE_W = 32,
  parameter int CNT_W  = SIZE_W - CHUNK_LOG + 1
) (
  input  logic [SIZE_W-1:0] size,
  output logic [CNT_W-1:0]  count,
  output logic              is_zero
);
  logic partial;
  assign partial = |size[CHUNK_LOG-1:0];
  assign count   = CNT_W'(size[SIZE_W-1:CHUNK_LOG]) + CNT_W'(partial);
  assign is_zero = (size == '0);
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import splitter_pkg::*;
#(
  parameter int SIZE_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SIZE_W-1:0]  size,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PHASE_W-1:0] phase,
  output logic               busy,
  output logic               dsc_valid,
  input  logic               dsc_ready,
  output logic [CTRL_W-1:0]  dsc_ctrl,
  output logic [ADDR_W-1:0]  dsc_addr
);
  localparam logic [SIZE_W-1:0] CHUNK_BYTES = SIZE_W'(1) << CHUNK_LOG;
  localparam logic [ADDR_W-1:0] CHUNK_STEP  = ADDR_W'(1) << CHUNK_LOG;

  logic [SIZE_W-1:0]  rem_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [PHASE_W-1:0] phase_q;
  logic               first_q;
  logic               busy_q;
  logic               final_beat;
  logic               take;

  assign final_beat = (rem_q <= CHUNK_BYTES);
  assign take       = busy_q && dsc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rem_q   <= '0;
      addr_q  <= '0;
      phase_q <= '0;
      first_q <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      rem_q   <= size;
      addr_q  <= addr;
      phase_q <= phase;
      first_q <= 1'b1;
    end else if (take) begin
      first_q <= 1'b0;
      if (final_beat) begin
        busy_q <= 1'b0;
      end else begin
        rem_q  <= rem_q - CHUNK_BYTES;
        addr_q <= addr_q + CHUNK_STEP;
      end
    end
  end

  always_comb begin
    dsc_ctrl = '0;
    dsc_ctrl[BIT_CONT]  = !final_beat;
    dsc_ctrl[BIT_END]   = final_beat;
    dsc_ctrl[BIT_START] = first_q;
    dsc_ctrl[PHASE_LO +: PHASE_W] = phase_q;
    dsc_ctrl[CHUNK_LOG-1:0] = final_beat ? rem_q[CHUNK_LOG-1:0] : '0;
  end

  assign dsc_valid = busy_q;
  assign dsc_addr  = addr_q;
  assign busy      = busy_q;

  // R9: offered descriptor is frozen under back-pressure
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_ctrl) && $stable(dsc_addr)));

  // R4: next address steps by one full chunk
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && dsc_ready && dsc_ctrl[BIT_CONT]) |=>
      (dsc_valid && dsc_addr == $past(dsc_addr) + CHUNK_STEP));

  // R3: exactly one of continue/end markers on an offered descriptor
  assert_marker_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> (dsc_ctrl[BIT_CONT] != dsc_ctrl[BIT_END]));

  // R2: non-final descriptors are full chunks encoded as length 0
  assert_full_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && dsc_ctrl[BIT_CONT]) |-> (dsc_ctrl[CHUNK_LOG-1:0] == '0));

  // R3: start marker only on the first beat after a taken descriptor it clears
  assert_start_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && dsc_ready && dsc_ctrl[BIT_CONT]) |=> !dsc_ctrl[BIT_START]);
endmodule

// File: rtl/desc_chain_splitter.sv
module desc_chain_splitter
  import splitter_pkg::*;
#(
  parameter int SIZE_W     = 32,
  parameter int ADDR_W     = 64,
  parameter int GEN_W      = 3,
  parameter int LEGACY_GEN = 2,
  parameter int TX_LEGACY  = 128,
  parameter int RX_LEGACY  = 128,
  parameter int TX_NEWER   = 65,
  parameter int RX_NEWER   = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_phase,
  input  logic [GEN_W-1:0]  req_gen,
  input  logic              req_dir,
  output logic              req_err,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [31:0]       dsc_ctrl,
  output logic [ADDR_W-1:0] dsc_addr
);
  localparam int CNT_W = SIZE_W - CHUNK_LOG + 1;

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] ceiling;
  logic             size_zero;
  logic             accept;
  logic             legal;
  logic             busy;
  logic             err_q;

  desc_count_calc #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_count (
    .size    (req_size),
    .count   (need),
    .is_zero (size_zero)
  );

  desc_limit_sel #(
    .GEN_W(GEN_W), .CNT_W(CNT_W), .LEGACY_GEN(LEGACY_GEN),
    .TX_LEGACY(TX_LEGACY), .RX_LEGACY(RX_LEGACY),
    .TX_NEWER(TX_NEWER), .RX_NEWER(RX_NEWER)
  ) u_limit (
    .gen   (req_gen),
    .dir   (xfer_dir_e'(req_dir)),
    .limit (ceiling)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign legal     = !size_zero && (need <= ceiling);

  desc_chain_seq #(.SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && legal),
    .size      (req_size),
    .addr      (req_addr),
    .phase     (req_phase),
    .busy      (busy),
    .dsc_valid (dsc_valid),
    .dsc_ready (dsc_ready),
    .dsc_ctrl  (dsc_ctrl),
    .dsc_addr  (dsc_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && !legal;
  end
  assign req_err = err_q;

  // R10: no request is taken while a chain is offered
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> !req_ready);

  // R7: a rejected request emits nothing
  assert_reject_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !dsc_valid);

  // R8: zero-size request is always refused
  assert_zero_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == '0) |=> (req_err && !dsc_valid));

  // R10: an accepted legal request is offered on the next cycle
  assert_start_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_err && req_size != '0 && need <= ceiling) |=>
      (dsc_valid && dsc_ctrl[BIT_START]));
endmodule

// File: tb/desc_chain_splitter_tb.sv
module desc_chain_splitter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_size = '0;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_phase = '0;
  logic [2:0]  req_gen = '0;
  logic        req_dir = 1'b0;
  logic        req_err;
  logic        dsc_valid;
  logic        dsc_ready = 1'b1;
  logic [31:0] dsc_ctrl;
  logic [63:0] dsc_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  desc_chain_splitter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .req_phase(req_phase),
    .req_gen(req_gen), .req_dir(req_dir), .req_err(req_err),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_ctrl(dsc_ctrl), .dsc_addr(dsc_addr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [31:0] size, input logic [63:0] addr,
                          input logic [1:0] ph, input logic [2:0] gen, input logic dir);
    int guard = 0;
    while (!req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    req_size = size; req_addr = addr; req_phase = ph; req_gen = gen; req_dir = dir;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_ctrl(input int i, input int n, input logic [31:0] size,
                                           input logic [1:0] ph);
    logic [31:0] c = '0;
    logic last = (i == n - 1);
    logic [31:0] remain = size - 32'(i) * 32'h10000;
    c[31] = !last;
    c[27] = last;
    c[26] = (i == 0);
    c[25:24] = ph;
    c[15:0] = last ? remain[15:0] : 16'h0;
    return c;
  endfunction

  // Emits a legal chain and checks every descriptor; stall_every=0 means no stalls
  task automatic run_chain(input string tag, input logic [31:0] size, input logic [63:0] addr,
                           input logic [1:0] ph, input logic [2:0] gen, input logic dir,
                           input int stall_every);
    int n = int'((64'(size) + 64'hFFFF) >> 16);
    send_req(size, addr, ph, gen, dir);
    check({tag, " R10 ready low after accept"}, 64'(req_ready), 64'd0);
    check({tag, " R10 first offered next cycle"}, 64'(dsc_valid), 64'd1);
    for (int i = 0; i < n; i++) begin
      int guard = 0;
      while (!dsc_valid && guard < 100) begin
        @(negedge clk);
        guard++;
      end
      check({tag, " R2 R3 ctrl"}, 64'(dsc_ctrl), 64'(exp_ctrl(i, n, size, ph)));
      check({tag, " R4 addr"}, dsc_addr, addr + 64'(i) * 64'h10000);
      if (stall_every != 0 && (i % stall_every == 0 || i == n - 1)) begin
        logic [31:0] c0 = dsc_ctrl;
        logic [63:0] a0 = dsc_addr;
        dsc_ready = 1'b0;
        @(negedge clk);
        check({tag, " R9 valid held"}, 64'(dsc_valid), 64'd1);
        check({tag, " R9 ctrl held"}, 64'(dsc_ctrl), 64'(c0));
        check({tag, " R9 addr held"}, dsc_addr, a0);
        dsc_ready = 1'b1;
      end
      @(negedge clk);
    end
    check({tag, " R10 ready after final"}, 64'(req_ready), 64'd1);
    check({tag, " R10 chain ended"}, 64'(dsc_valid), 64'd0);
  endtask

  task automatic run_reject(input string tag, input logic [31:0] size, input logic [2:0] gen,
                            input logic dir);
    send_req(size, 64'h1000, 2'd2, gen, dir);
    check({tag, " err pulse"}, 64'(req_err), 64'd1);
    check({tag, " nothing emitted"}, 64'(dsc_valid), 64'd0);
    @(negedge clk);
    check({tag, " err one cycle"}, 64'(req_err), 64'd0);
    check({tag, " still nothing emitted"}, 64'(dsc_valid), 64'd0);
    check({tag, " ready again"}, 64'(req_ready), 64'd1);
  endtask

  task automatic test_reset();
    check("R1 dsc_valid", 64'(dsc_valid), 64'd0);
    check("R1 req_err", 64'(req_err), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_chain("small single R3", 32'd100, 64'h0000_0010_0000_0000, 2'd1, 3'd2, 1'b0, 1);
    run_chain("exact 64K single R2", 32'h10000, 64'h2000, 2'd3, 3'd3, 1'b1, 0);
    run_chain("64K plus one R2", 32'h10001, 64'hABC0_0000, 2'd2, 3'd4, 1'b0, 1);
    run_chain("three full R2", 32'h30000, 64'h5_0000_0000, 2'd0, 3'd3, 1'b1, 2);
    run_chain("remainder R4", 32'h0004_1234, 64'h77, 2'd1, 3'd2, 1'b1, 3);
    run_reject("zero size R8", 32'd0, 3'd2, 1'b0);
    run_chain("tx new at ceiling R5", 32'd65 * 32'h10000, 64'h100_0000, 2'd1, 3'd3, 1'b0, 16);
    run_reject("tx new over R7 R5", 32'd65 * 32'h10000 + 32'd1, 3'd4, 1'b0);
    run_chain("rx new at ceiling R6", 32'd60 * 32'h10000 - 32'd5, 64'h300_0000, 2'd2, 3'd4, 1'b1, 0);
    run_reject("rx new over R7 R6", 32'd60 * 32'h10000 + 32'd5, 3'd3, 1'b1);
    run_chain("tx legacy at ceiling R5", 32'd128 * 32'h10000, 64'h4000_0000, 2'd3, 3'd2, 1'b0, 0);
    run_reject("tx legacy over R7 R5", 32'd128 * 32'h10000 + 32'd1, 3'd2, 1'b0);
    run_chain("rx legacy beyond new ceiling R6", 32'd100 * 32'h10000, 64'h8000, 2'd0, 3'd2, 1'b1, 0);
    run_reject("rx legacy over R7 R6", 32'd129 * 32'h10000, 3'd2, 1'b1);
    run_reject("tx new 128 chunks R7", 32'd128 * 32'h10000, 3'd3, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule